// File: doc/BRIEF.md
# Pipeline Hazard Stall/Bubble Controller

This block decides, every cycle, which pipeline registers of a five-stage in-order core (fetch, decode, execute, memory, write-back) hold their contents and which are overwritten with a no-op. It also tells fetch where its next address comes from. It watches the opcode in each stage, the source registers of the instruction in decode, the load destination and jump function of the instruction in execute, and the condition result that execute computes for conditional jumps.

Three hazards are handled. A load whose result is needed by the very next instruction costs one cycle: fetch and decode hold, and execute gets a no-op. A return is never predicted: fetch holds and decode is fed no-ops until the return reaches write-back, where its popped address is used. That costs three no-ops. Calls and jumps are predicted to go to their target. A conditional jump that turns out not taken cancels the two instructions fetched behind it, and fetch restarts one cycle later at the fall-through address that travels with the jump. A no-op inserted this way changes no register, memory, condition flag or status. A held stage keeps its register value unchanged.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: Reset is synchronous and active high. In the first cycle after a reset cycle, `fetch_src` is 0 (predicted address), even if a mispredicting jump was on the execute inputs during reset.
- R2: Load-use rule. A load in execute (`exe_op` 0x5 or 0xB) whose `exe_dst_ld` is not 0xF and equals `dec_src_a` or `dec_src_b` sets `stage_hold` bits 0 (fetch) and 1 (decode) and `stage_flush` bit 2 (execute). Decode is not flushed.
- R3: Nothing is held or flushed for a load whose destination is 0xF, for a non-load op whose destination matches, or for a load whose destination matches neither decode source.
- R4: A return (opcode 0x9) in decode, execute or memory sets `stage_hold` bit 0 and `stage_flush` bit 1.
- R5: A return in write-back gives `fetch_src` = 2 (popped return address). A pending misprediction recovery (`fetch_src` = 1) takes priority over this.
- R6: Misprediction rule. `exe_op` 0x7 with nonzero `exe_fn` and `exe_cond_ok` = 0 flushes decode and execute (`stage_flush` bits 1 and 2) in the same cycle. `fetch_src` is 1 (fall-through) in exactly the next cycle.
- R7: A jump with `exe_fn` 0 (unconditional), or with `exe_cond_ok` = 1, causes no flush and no recovery.
- R8: `pred_target` is 1 exactly when `fch_op` is 0x7 (jump) or 0x8 (call).
- R9: A misprediction together with a return in decode flushes decode and execute and does not hold fetch. The return is cancelled, not waited for.
- R10: A load-use hazard together with a return in decode holds fetch and decode and flushes execute, with no decode flush.
- R11: Memory and write-back bits (3 and 4) are never held or flushed. No stage is held and flushed in the same cycle.
- R12: Running a program through a pipeline driven by these controls costs one bubble per load-use pair, two per mispredicted jump and three per return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fch_op | input | 4 | Opcode of the instruction being fetched |
| dec_op | input | 4 | Opcode in decode |
| dec_src_a | input | REGW | First source register in decode (0xF = none) |
| dec_src_b | input | REGW | Second source register in decode (0xF = none) |
| exe_op | input | 4 | Opcode in execute |
| exe_fn | input | FNW | Function code in execute (0 = unconditional jump) |
| exe_dst_ld | input | REGW | Memory-load destination in execute (0xF = none) |
| exe_cond_ok | input | 1 | Jump condition evaluated in execute |
| mem_op | input | 4 | Opcode in memory stage |
| wb_op | input | 4 | Opcode in write-back |
| stage_hold | output | 5 | Per-stage hold, bit 0 fetch to bit 4 write-back |
| stage_flush | output | 5 | Per-stage no-op injection, same bit order |
| fetch_src | output | 2 | 0 predicted, 1 fall-through, 2 return address |
| pred_target | output | 1 | Next prediction uses the fetched instruction's target |

## Verification
The hard cases are hazards that arrive together. With a misprediction and a return in decode at once, a controller that gives the return priority would hold fetch for a path that is being discarded. With a load-use hazard and a return in decode at once, a controller that flushes decode would lose the consumer instead of replaying it. The bench also tests that recovery lasts exactly one cycle and that unconditional jumps and taken conditional jumps never flush. A stuck or doubled recovery would fetch the fall-through path twice. A final program-level run counts bubbles per hazard class, so a controller that drains a return one cycle short, or cancels only one wrong-path instruction, changes the totals.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int OPW    = 4;
  localparam int NSTAGE = 5;

  localparam int ST_F = 0;
  localparam int ST_D = 1;
  localparam int ST_E = 2;
  localparam int ST_M = 3;
  localparam int ST_W = 4;

  localparam logic [OPW-1:0] OP_HALT = 4'h0;
  localparam logic [OPW-1:0] OP_NOP  = 4'h1;
  localparam logic [OPW-1:0] OP_LOAD = 4'h5;
  localparam logic [OPW-1:0] OP_JMP  = 4'h7;
  localparam logic [OPW-1:0] OP_CALL = 4'h8;
  localparam logic [OPW-1:0] OP_RET  = 4'h9;
  localparam logic [OPW-1:0] OP_POP  = 4'hB;

  typedef enum logic [1:0] {
    PCS_PRED = 2'd0,
    PCS_FALL = 2'd1,
    PCS_RET  = 2'd2
  } pcsel_e;
endpackage

// File: rtl/hz_loaduse_det.sv
module hz_loaduse_det
  import hz_pkg::*;
#(
  parameter int REGW = 4,
  parameter logic [REGW-1:0] REG_NONE = '1
) (
  input  logic [OPW-1:0]  exe_op,
  input  logic [REGW-1:0] exe_dst_ld,
  input  logic [REGW-1:0] dec_src_a,
  input  logic [REGW-1:0] dec_src_b,
  output logic            load_use
);
  logic is_load;
  logic dst_valid;
  logic hit;

  always_comb begin
    is_load   = (exe_op == OP_LOAD) || (exe_op == OP_POP);
    dst_valid = (exe_dst_ld != REG_NONE);
    hit       = (exe_dst_ld == dec_src_a) || (exe_dst_ld == dec_src_b);
    load_use  = is_load && dst_valid && hit;
  end
endmodule

// File: rtl/hz_ret_track.sv
module hz_ret_track
  import hz_pkg::*;
(
  input  logic [OPW-1:0] dec_op,
  input  logic [OPW-1:0] exe_op,
  input  logic [OPW-1:0] mem_op,
  input  logic [OPW-1:0] wb_op,
  output logic           ret_dec,
  output logic           ret_deep,
  output logic           ret_wb
);
  always_comb begin
    ret_dec  = (dec_op == OP_RET);
    ret_deep = (exe_op == OP_RET) || (mem_op == OP_RET);
    ret_wb   = (wb_op == OP_RET);
  end
endmodule

// File: rtl/hz_branch_unit.sv
module hz_branch_unit
  import hz_pkg::*;
#(
  parameter int FNW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] fch_op,
  input  logic [OPW-1:0] exe_op,
  input  logic [FNW-1:0] exe_fn,
  input  logic           exe_cond_ok,
  output logic           mispredict,
  output logic           recover_q,
  output logic           pred_target
);
  always_comb begin
    mispredict  = (exe_op == OP_JMP) && (exe_fn != '0) && !exe_cond_ok;
    pred_target = (fch_op == OP_JMP) || (fch_op == OP_CALL);
  end

  always_ff @(posedge clk) begin
    if (rst) recover_q <= 1'b0;
    else     recover_q <= mispredict;
  end
endmodule

// File: rtl/hz_pipe_ctrl.sv
module hz_pipe_ctrl
  import hz_pkg::*;
#(
  parameter int REGW = 4,
  parameter int FNW  = 4,
  parameter logic [REGW-1:0] REG_NONE = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OPW-1:0]     fch_op,
  input  logic [OPW-1:0]     dec_op,
  input  logic [REGW-1:0]    dec_src_a,
  input  logic [REGW-1:0]    dec_src_b,
  input  logic [OPW-1:0]     exe_op,
  input  logic [FNW-1:0]     exe_fn,
  input  logic [REGW-1:0]    exe_dst_ld,
  input  logic               exe_cond_ok,
  input  logic [OPW-1:0]     mem_op,
  input  logic [OPW-1:0]     wb_op,
  output logic [NSTAGE-1:0]  stage_hold,
  output logic [NSTAGE-1:0]  stage_flush,
  output logic [1:0]         fetch_src,
  output logic               pred_target
);
  logic load_use;
  logic ret_dec, ret_deep, ret_wb;
  logic mispredict, recover_q;
  logic ret_live;
  logic [NSTAGE-1:0] hold_req;
  logic [NSTAGE-1:0] flush_req;

  hz_loaduse_det #(.REGW(REGW), .REG_NONE(REG_NONE)) u_lu (
    .exe_op     (exe_op),
    .exe_dst_ld (exe_dst_ld),
    .dec_src_a  (dec_src_a),
    .dec_src_b  (dec_src_b),
    .load_use   (load_use)
  );

  hz_ret_track u_ret (
    .dec_op   (dec_op),
    .exe_op   (exe_op),
    .mem_op   (mem_op),
    .wb_op    (wb_op),
    .ret_dec  (ret_dec),
    .ret_deep (ret_deep),
    .ret_wb   (ret_wb)
  );

  hz_branch_unit #(.FNW(FNW)) u_br (
    .clk         (clk),
    .rst         (rst),
    .fch_op      (fch_op),
    .exe_op      (exe_op),
    .exe_fn      (exe_fn),
    .exe_cond_ok (exe_cond_ok),
    .mispredict  (mispredict),
    .recover_q   (recover_q),
    .pred_target (pred_target)
  );

  // A return in decode behind a mispredicted jump is on the wrong path: it is cancelled, not waited for.
  always_comb begin
    ret_live  = (ret_dec && !mispredict) || ret_deep;
    hold_req  = '0;
    flush_req = '0;
    hold_req[ST_F]  = load_use || ret_live;
    hold_req[ST_D]  = load_use;
    flush_req[ST_D] = mispredict || (ret_live && !load_use);
    flush_req[ST_E] = mispredict || load_use;
  end

  // Per-stage resolver: a flush overrides a hold on the same register.
  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    always_comb begin
      stage_flush[g] = flush_req[g];
      stage_hold[g]  = hold_req[g] && !flush_req[g];
    end
  end

  always_comb begin
    if (recover_q)   fetch_src = PCS_FALL;
    else if (ret_wb) fetch_src = PCS_RET;
    else             fetch_src = PCS_PRED;
  end

  // R2
  dec_hold_feeds_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    stage_hold[ST_D] |-> (stage_flush[ST_E] && stage_hold[ST_F] && !stage_flush[ST_D]));

  // R6
  fallthru_next_chk: assert property (@(posedge clk) disable iff (rst)
    (exe_op == OP_JMP && exe_fn != '0 && !exe_cond_ok) |=> (fetch_src == PCS_FALL));

  // R9
  squash_path_chk: assert property (@(posedge clk) disable iff (rst)
    (exe_op == OP_JMP && exe_fn != '0 && !exe_cond_ok)
      |-> (!stage_hold[ST_F] && stage_flush[ST_D] && stage_flush[ST_E]));

  // R4
  ret_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (exe_op == OP_RET) |-> (stage_hold[ST_F] && stage_flush[ST_D]));

  // R5
  ret_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_op == OP_RET) |-> (fetch_src != PCS_PRED));
endmodule

// File: tb/tb_hz_pipe_ctrl.sv
`timescale 1ns/1ps
module tb_hz_pipe_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] fch_op, dec_op, dec_src_a, dec_src_b, exe_op, exe_fn, exe_dst_ld, mem_op, wb_op;
  logic exe_cond_ok;
  logic [4:0] stage_hold, stage_flush;
  logic [1:0] fetch_src;
  logic pred_target;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  hz_pipe_ctrl dut (
    .clk(clk), .rst(rst), .fch_op(fch_op), .dec_op(dec_op),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .exe_op(exe_op), .exe_fn(exe_fn),
    .exe_dst_ld(exe_dst_ld), .exe_cond_ok(exe_cond_ok), .mem_op(mem_op), .wb_op(wb_op),
    .stage_hold(stage_hold), .stage_flush(stage_flush), .fetch_src(fetch_src),
    .pred_target(pred_target)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Layout: f d sa sb | e efn edst cond | m w | hold[4:0] flush[4:0] pred
  localparam int NV = 20;
  localparam logic [47:0] VEC [NV] = '{
    {4'h1,4'h1,4'hF,4'hF, 4'h1,4'h0,4'hF,1'b1, 4'h1,4'h1, 5'b00000,5'b00000,1'b0}, // R3 idle
    {4'h3,4'h6,4'h1,4'h2, 4'h5,4'h0,4'h1,1'b1, 4'h1,4'h1, 5'b00011,5'b00100,1'b0}, // R2 srcA
    {4'h7,4'h6,4'h3,4'h7, 4'hB,4'h0,4'h7,1'b1, 4'h1,4'h1, 5'b00011,5'b00100,1'b1}, // R2 pop srcB, R8
    {4'h8,4'h6,4'h1,4'h2, 4'h5,4'h0,4'h4,1'b1, 4'h1,4'h1, 5'b00000,5'b00000,1'b1}, // R3 no match, R8
    {4'h1,4'h6,4'h1,4'h2, 4'h6,4'h0,4'h1,1'b1, 4'h1,4'h1, 5'b00000,5'b00000,1'b0}, // R3 not a load
    {4'h1,4'h6,4'hF,4'hF, 4'h5,4'h0,4'hF,1'b1, 4'h1,4'h1, 5'b00000,5'b00000,1'b0}, // R3 dst none
    {4'h1,4'h9,4'h4,4'h4, 4'h1,4'h0,4'hF,1'b1, 4'h1,4'h1, 5'b00001,5'b00010,1'b0}, // R4 ret D
    {4'h1,4'h1,4'hF,4'hF, 4'h9,4'h0,4'hF,1'b1, 4'h1,4'h1, 5'b00001,5'b00010,1'b0}, // R4 ret E
    {4'h1,4'h1,4'hF,4'hF, 4'h1,4'h0,4'hF,1'b1, 4'h9,4'h1, 5'b00001,5'b00010,1'b0}, // R4 ret M
    {4'h1,4'h1,4'hF,4'hF, 4'h1,4'h0,4'hF,1'b1, 4'h1,4'h9, 5'b00000,5'b00000,1'b0}, // R5 ret W
    {4'h1,4'h1,4'hF,4'hF, 4'h7,4'h1,4'hF,1'b0, 4'h1,4'h1, 5'b00000,5'b00110,1'b0}, // R6 mispredict
    {4'h1,4'h1,4'hF,4'hF, 4'h1,4'h0,4'hF,1'b1, 4'h1,4'h1, 5'b00000,5'b00000,1'b0}, // R6 recovery
    {4'h1,4'h1,4'hF,4'hF, 4'h1,4'h0,4'hF,1'b1, 4'h1,4'h9, 5'b00000,5'b00000,1'b0}, // R6 one cycle, R5
    {4'h1,4'h1,4'hF,4'hF, 4'h7,4'h0,4'hF,1'b0, 4'h1,4'h1, 5'b00000,5'b00000,1'b0}, // R7 uncond
    {4'h1,4'h1,4'hF,4'hF, 4'h7,4'h2,4'hF,1'b1, 4'h1,4'h1, 5'b00000,5'b00000,1'b0}, // R7 taken
    {4'h1,4'h1,4'hF,4'hF, 4'h1,4'h0,4'hF,1'b1, 4'h1,4'h1, 5'b00000,5'b00000,1'b0}, // R7 no recovery
    {4'h1,4'h9,4'h4,4'h4, 4'h7,4'h3,4'hF,1'b0, 4'h1,4'h1, 5'b00000,5'b00110,1'b0}, // R9
    {4'h1,4'h9,4'h4,4'h4, 4'hB,4'h0,4'h4,1'b1, 4'h1,4'h9, 5'b00011,5'b00100,1'b0}, // R10, R5 priority
    {4'h1,4'h9,4'h4,4'h4, 4'h1,4'h0,4'hF,1'b1, 4'h9,4'h1, 5'b00001,5'b00010,1'b0}, // R4 ret D+M
    {4'h8,4'h1,4'hF,4'hF, 4'h1,4'h0,4'hF,1'b1, 4'h1,4'h1, 5'b00000,5'b00000,1'b1}  // R8, R11
  };

  // Bench-side pipeline model for the program-level run (R12)
  typedef struct packed {
    logic bub; logic [3:0] op, fn, sa, sb, dm; logic tk; logic [7:0] pc, tgt;
  } ins_t;

  function automatic ins_t mk(input logic [7:0] pc, input logic [3:0] op, fn, sa, sb, dm,
                              input logic tk, input logic [7:0] tgt);
    mk = '{bub:1'b0, op:op, fn:fn, sa:sa, sb:sb, dm:dm, tk:tk, pc:pc, tgt:tgt};
  endfunction

  function automatic ins_t prog(input logic [7:0] pc);
    case (pc)
      8'd1:    prog = mk(pc, 4'h5, 4'h0, 4'h0, 4'hF, 4'h1, 1'b1, 8'd0);  // load r1
      8'd2:    prog = mk(pc, 4'h6, 4'h0, 4'h1, 4'h2, 4'hF, 1'b1, 8'd0);  // uses r1
      8'd3:    prog = mk(pc, 4'h8, 4'h0, 4'hF, 4'h4, 4'hF, 1'b1, 8'd10); // call
      8'd4:    prog = mk(pc, 4'h7, 4'h1, 4'hF, 4'hF, 4'hF, 1'b0, 8'd7);  // cond jump, not taken
      8'd6:    prog = mk(pc, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF, 1'b1, 8'd0);  // halt
      8'd11:   prog = mk(pc, 4'h9, 4'h0, 4'h4, 4'h4, 4'hF, 1'b1, 8'd4);  // return to 4
      default: prog = mk(pc, 4'h3, 4'h0, 4'hF, 4'hF, 4'hF, 1'b1, 8'd0);  // immediate move
    endcase
  endfunction

  localparam ins_t BUB = '{bub:1'b1, op:4'h1, fn:4'h0, sa:4'hF, sb:4'hF, dm:4'hF,
                           tk:1'b1, pc:8'd0, tgt:8'd0};

  ins_t rD, rE, rM, rW;
  logic [7:0] f_pred;

  task automatic drive_model();
    dec_op = rD.op; dec_src_a = rD.sa; dec_src_b = rD.sb;
    exe_op = rE.op; exe_fn = rE.fn; exe_dst_ld = rE.dm; exe_cond_ok = rE.tk;
    mem_op = rM.op; wb_op = rW.op;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic prev_misp;
    int exp_pc;
    // R1: mispredict present during reset must not trigger recovery
    fch_op = 4'h1; dec_op = 4'h1; dec_src_a = 4'hF; dec_src_b = 4'hF;
    exe_op = 4'h7; exe_fn = 4'h1; exe_dst_ld = 4'hF; exe_cond_ok = 1'b0;
    mem_op = 4'h1; wb_op = 4'h1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0; exe_op = 4'h1; exe_fn = 4'h0; exe_cond_ok = 1'b1;
    @(negedge clk);
    chk("R1 fetch_src after reset", fetch_src, 0);
    chk("R1 hold after reset", stage_hold, 0);
    chk("R1 flush after reset", stage_flush, 0);

    prev_misp = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      @(posedge clk); #1;
      fch_op = v[47:44]; dec_op = v[43:40]; dec_src_a = v[39:36]; dec_src_b = v[35:32];
      exe_op = v[31:28]; exe_fn = v[27:24]; exe_dst_ld = v[23:20]; exe_cond_ok = v[19];
      mem_op = v[18:15]; wb_op = v[14:11];
      @(negedge clk);
      exp_pc = prev_misp ? 1 : (v[14:11] == 4'h9 ? 2 : 0);
      chk($sformatf("R2/R3/R4/R9/R10/R11 hold vec%0d", i), stage_hold, v[10:6]);
      chk($sformatf("R2/R4/R6/R7/R11 flush vec%0d", i), stage_flush, v[5:1]);
      chk($sformatf("R8 pred_target vec%0d", i), pred_target, v[0]);
      chk($sformatf("R5/R6/R7 fetch_src vec%0d", i), fetch_src, exp_pc);
      prev_misp = (v[31:28] == 4'h7) && (v[27:24] != 4'h0) && !v[19];
    end

    // R12: program-level run with one load-use pair, one call/return, one mispredicted jump
    begin
      int retired, pcsum, wbubs, lu_ev, mp_ev, rt_ev;
      logic seen, done;
      logic [7:0] fpc, npred;
      ins_t fi;
      retired = 0; pcsum = 0; wbubs = 0; lu_ev = 0; mp_ev = 0; rt_ev = 0;
      seen = 1'b0; done = 1'b0;
      @(posedge clk); #1;
      rD = BUB; rE = BUB; rM = BUB; rW = BUB; f_pred = 8'd0;
      drive_model();
      fch_op = prog(f_pred).op;
      for (int c = 0; c < 200 && !done; c++) begin
        @(negedge clk);
        case (fetch_src)
          2'd1:    fpc = rM.pc + 8'd1;
          2'd2:    fpc = rW.tgt;
          default: fpc = f_pred;
        endcase
        fi = prog(fpc);
        fch_op = fi.op;
        #1;
        npred = pred_target ? fi.tgt : fpc + 8'd1;
        if (!rW.bub) begin
          seen = 1'b1; retired++; pcsum += int'(rW.pc);
          if (rW.op == 4'h0) done = 1'b1;
        end else if (seen) wbubs++;
        if (!done) begin
          if (stage_flush[2] && stage_hold[1]) lu_ev++;
          if (stage_flush[1] && stage_flush[2]) mp_ev++;
          if (stage_flush[1] && !stage_flush[2]) rt_ev++;
          @(posedge clk); #1;
          rW = rM; rM = rE;
          rE = stage_flush[2] ? BUB : rD;
          rD = stage_flush[1] ? BUB : (stage_hold[1] ? rD : fi);
          if (!stage_hold[0]) f_pred = npred;
          drive_model();
          case (fetch_src)
            default: fch_op = prog(f_pred).op;
          endcase
        end
      end
      chk("R12 program reached halt", done, 1);
      chk("R12 retired instructions", retired, 9);
      chk("R12 retired path checksum", pcsum, 42);
      chk("R12 total bubbles", wbubs, 6);
      chk("R12 load-use bubbles", lu_ev, 1);
      chk("R12 mispredict events", mp_ev, 1);
      chk("R12 return bubbles", rt_ev, 3);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule